// File: doc/BRIEF.md
# 100BASE-TX Transmit PCS Encoder

This block turns a nibble-wide transmit stream into the three-level serial line signal of a 100 Mb/s twisted-pair link. It runs on a single 125 MHz bit clock. Once in every five clocks it takes one 4-bit nibble together with a frame-enable flag and an error flag. It maps each nibble slot to a 5-bit code group and shifts that group out most significant bit first. Each line bit is XORed with an 11-bit free-running keystream, and the result is encoded as an MLT-3 level.

A frame begins when the enable flag is first seen high. The first two nibbles of that frame are the first preamble octet. They are not forwarded; the start delimiter pair goes out in their place. When the enable flag is first seen low, the end delimiter pair is sent, and idle code groups follow. Idle groups are also sent from reset onward whenever no frame is active.

The line rate is fixed, so the input has no ready signal and cannot be stalled. The block drives `tx_nib_tick` high for one clock in every five. A nibble is accepted only at a rising edge where `tx_nib_tick` is high. The source must present its next nibble while that strobe is high, and it has no way to hold off the block. Input values present at any other edge are ignored.

Top module: `tx100_pcs_enc`

## Requirements
- R1: While `rst_n` is low, `line_lvl` is 0 and `tx_nib_tick` is low. After release, the code groups are idle from the first slot, and the MLT-3 state starts at level 0, heading next to +1.
- R2: `tx_nib_tick` is high for exactly one clock in every five, first in the fifth clock after reset release. Inputs are sampled only at edges where it is high, and input changes at other edges have no effect on `line_lvl`.
- R3: The first sampled nibble with `tx_en` high is sent as J (11000) and the next nibble slot as K (10001), whatever `txd` and `tx_er` hold in those slots.
- R4: Later nibbles sampled with `tx_en` high and `tx_er` low are sent with this 4B/5B mapping (hex nibble to code): 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: A data nibble sampled with `tx_en` and `tx_er` both high is sent as H (00100).
- R6: The first data-phase nibble sampled with `tx_en` low is sent as T (01101), and the next slot as R (00111). If `tx_en` is high in the R slot, that nibble is ignored, and framing restarts from the following slot.
- R7: Between frames each slot carries idle (11111).
- R8: Each code group is sent one bit per clock, leftmost bit first, in the five clocks that follow the edge that sampled its nibble.
- R9: Each line bit is the code bit XOR key. The key is bit 10 XOR bit 8 of an 11-bit register (polynomial x^11+x^9+1). That register is seeded with `LFSR_SEED` on reset and shifts left every clock, with the key entering bit 0.
- R10: The level after each clock advances through the cycle 0, +1, 0, -1 when the scrambled bit is 1, and holds when it is 0. `line_lvl` is two's complement: 00 for 0, 01 for +1, 11 for -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable for the nibble being offered |
| tx_er | input | 1 | Error flag for the nibble being offered |
| txd | input | 4 | Transmit nibble |
| tx_nib_tick | output | 1 | Nibble acceptance strobe, one clock in five |
| line_lvl | output | 2 | Signed MLT-3 line level |

## Verification
The hardest conditions to reach are at the slot boundaries: a frame whose enable drops during the K slot, and an enable that rises again in the very R slot that ends the previous frame. Both depend on where the enable changes relative to the one-in-five strobe. The bench aligns every nibble to `tx_nib_tick` so that it can place an edge in any chosen slot. In some frames it also drives random values on the inputs in the four clocks between strobes, to show that those values are ignored.

// File: rtl/tx_pcs_pkg.sv
package tx_pcs_pkg;

  localparam int CG_W = 5;
  typedef logic [CG_W-1:0] cg_t;

  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_J    = 5'b11000;
  localparam cg_t CG_K    = 5'b10001;
  localparam cg_t CG_T    = 5'b01101;
  localparam cg_t CG_R    = 5'b00111;
  localparam cg_t CG_H    = 5'b00100;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_SEND_K,
    FS_DATA,
    FS_SEND_R
  } frm_state_e;

  localparam logic signed [1:0] LVL_ZERO = 2'sb00;
  localparam logic signed [1:0] LVL_POS  = 2'sb01;
  localparam logic signed [1:0] LVL_NEG  = 2'sb11;

  function automatic cg_t map_4b5b(input logic [3:0] nib);
    cg_t c;
    case (nib)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/txp_slot_timer.sv
module txp_slot_timer #(
  parameter int SLOT_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PH_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_LEN - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (phase_q == PH_LAST) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == PH_LAST);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/txp_framer.sv
module txp_framer
  import tx_pcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output cg_t        cg_next
);
  frm_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    cg_next = CG_IDLE;
    unique case (st_q)
      FS_IDLE: begin
        if (tx_en) begin
          cg_next = CG_J;
          st_d    = FS_SEND_K;
        end
      end
      FS_SEND_K: begin
        cg_next = CG_K;
        st_d    = FS_DATA;
      end
      FS_DATA: begin
        if (!tx_en) begin
          cg_next = CG_T;
          st_d    = FS_SEND_R;
        end else if (tx_er) begin
          cg_next = CG_H;
        end else begin
          cg_next = map_4b5b(txd);
        end
      end
      default: begin
        cg_next = CG_R;
        st_d    = FS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= FS_IDLE;
    else if (tick) st_q <= st_d;
  end

  // R6
  r_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && st_q == FS_SEND_R) |=> (st_q == FS_IDLE));

  // R3
  j_then_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && st_q == FS_IDLE && tx_en) |=> (st_q == FS_SEND_K));

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(st_q));

endmodule

// File: rtl/txp_serializer.sv
module txp_serializer
  import tx_pcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cg_t  cg_in,
  output logic bit_out
);
  cg_t sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sreg_q <= CG_IDLE;
    else if (load) sreg_q <= cg_in;
    else           sreg_q <= {sreg_q[CG_W-2:0], 1'b0};
  end

  assign bit_out = sreg_q[CG_W-1];

endmodule

// File: rtl/txp_scrambler.sv
module txp_scrambler #(
  parameter int POLY_HI = 11,
  parameter int POLY_LO = 9,
  parameter logic [POLY_HI-1:0] SEED = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic plain_bit,
  output logic scr_bit
);
  localparam int TAP_A = POLY_HI - 1;
  localparam int TAP_B = POLY_LO - 1;

  logic [POLY_HI-1:0] lfsr_q;
  logic               key;

  assign key     = lfsr_q[TAP_A] ^ lfsr_q[TAP_B];
  assign scr_bit = plain_bit ^ key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= {lfsr_q[POLY_HI-2:0], key};
  end

  // R9
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

// File: rtl/txp_mlt3.sv
module txp_mlt3
  import tx_pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  output logic signed [1:0] lvl
);
  logic [1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_q <= 2'd0;
    else if (bit_in) step_q <= step_q + 2'd1;
  end

  always_comb begin
    if (!step_q[0])     lvl = LVL_ZERO;
    else if (step_q[1]) lvl = LVL_NEG;
    else                lvl = LVL_POS;
  end

  // R10
  mlt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_in |=> $stable(lvl));

  // R10
  mlt_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_in |=> (lvl != $past(lvl)));

endmodule

// File: rtl/tx100_pcs_enc.sv
module tx100_pcs_enc
  import tx_pcs_pkg::*;
#(
  parameter int           LFSR_HI   = 11,
  parameter int           LFSR_LO   = 9,
  parameter logic [LFSR_HI-1:0] LFSR_SEED = 11'h5A3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [3:0]        txd,
  output logic              tx_nib_tick,
  output logic signed [1:0] line_lvl
);
  cg_t  cg_next;
  logic code_bit;
  logic scr_bit;

  txp_slot_timer #(.SLOT_LEN(CG_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tx_nib_tick)
  );

  txp_framer u_framer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tx_nib_tick),
    .tx_en  (tx_en),
    .tx_er  (tx_er),
    .txd    (txd),
    .cg_next(cg_next)
  );

  txp_serializer u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tx_nib_tick),
    .cg_in  (cg_next),
    .bit_out(code_bit)
  );

  txp_scrambler #(
    .POLY_HI(LFSR_HI),
    .POLY_LO(LFSR_LO),
    .SEED   (LFSR_SEED)
  ) u_scr (
    .clk      (clk),
    .rst_n    (rst_n),
    .plain_bit(code_bit),
    .scr_bit  (scr_bit)
  );

  txp_mlt3 u_mlt (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_in(scr_bit),
    .lvl   (line_lvl)
  );

  // R1
  reset_level_chk: assert property (@(posedge clk)
    !rst_n |-> (line_lvl == LVL_ZERO));

endmodule

// File: tb/tx100_pcs_enc_test.sv
`timescale 1ns/1ps
module tx100_pcs_enc_test;
  localparam logic [10:0] SEED = 11'h3C5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic tick;
  logic signed [1:0] lvl;
  bit noise = 1'b0;
  bit done = 1'b0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tx100_pcs_enc #(.LFSR_SEED(SEED)) uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .tx_nib_tick(tick), .line_lvl(lvl)
  );

  // reference model state
  logic [4:0]  m_cg;
  int          m_idx;
  logic [10:0] m_lfsr;
  int          m_step;
  int          m_fs;
  string       m_tag;

  function automatic logic [4:0] code_of(input logic [3:0] n);
    logic [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return tbl[n];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cg = 5'b11111; m_idx = 0; m_lfsr = SEED; m_step = 0; m_fs = 0; m_tag = "R1";
    end else begin
      logic p, k;
      p = m_cg[4 - m_idx];
      k = m_lfsr[10] ^ m_lfsr[8];
      m_lfsr = {m_lfsr[9:0], k};
      if (p ^ k) m_step = (m_step + 1) % 4;
      if (m_idx == 4) begin
        m_idx = 0;
        case (m_fs)
          0: if (tx_en) begin m_cg = 5'b11000; m_fs = 1; m_tag = "R3"; end
             else begin m_cg = 5'b11111; m_tag = "R7"; end
          1: begin m_cg = 5'b10001; m_fs = 2; m_tag = "R3"; end
          2: if (!tx_en) begin m_cg = 5'b01101; m_fs = 3; m_tag = "R6"; end
             else if (tx_er) begin m_cg = 5'b00100; m_tag = "R5"; end
             else begin m_cg = code_of(txd); m_tag = "R4"; end
          default: begin m_cg = 5'b00111; m_fs = 0; m_tag = "R6"; end
        endcase
      end else begin
        m_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(lvl == 2'sb00, "R1 level in reset", int'(lvl), 0);
      chk(tick == 1'b0, "R1 strobe in reset", int'(tick), 0);
    end else if (!done) begin
      int exp;
      exp = (m_step == 1) ? 1 : (m_step == 3) ? -1 : 0;
      chk(int'(lvl) == exp, {"R8 R9 R10 level, slot ", m_tag}, int'(lvl), exp);
      chk(tick == (m_idx == 4), "R2 strobe", int'(tick), int'(m_idx == 4));
    end
  end

  task automatic put_nib(input bit en, input bit er, input logic [3:0] d);
    @(negedge clk);
    while (!tick) begin
      if (noise) begin
        tx_en = 1'($urandom); tx_er = 1'($urandom); txd = 4'($urandom);
      end
      @(negedge clk);
    end
    tx_en = en; tx_er = er; txd = d;
  endtask

  task automatic frame_body(input int ndata, input int er_at);
    for (int i = 0; i < 15; i++) put_nib(1'b1, 1'b0, 4'h5);
    put_nib(1'b1, 1'b0, 4'hD);
    for (int i = 0; i < ndata; i++) put_nib(1'b1, i == er_at, 4'(i * 7 + 3));
  endtask

  task automatic idle_nibs(input int n);
    for (int i = 0; i < n; i++) put_nib(1'b0, 1'b0, 4'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle_nibs(8);                       // R1 R7
    frame_body(32, -1);                 // R3 R4
    idle_nibs(6);                       // R6 R7
    noise = 1'b1;                       // R2: junk between strobes
    frame_body(20, 5);                  // R5
    idle_nibs(4);
    noise = 1'b0;
    put_nib(1'b1, 1'b1, 4'hA);          // R3: J regardless of data
    put_nib(1'b1, 1'b1, 4'h0);          // R3: K regardless of error
    idle_nibs(4);                       // R6: T then R
    put_nib(1'b1, 1'b0, 4'h2);          // enable drops during K slot
    idle_nibs(5);
    frame_body(6, -1);
    put_nib(1'b0, 1'b0, 4'h0);          // T
    put_nib(1'b1, 1'b0, 4'h9);          // R6: ignored in R slot
    frame_body(4, 2);
    idle_nibs(10);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

endmodule